// File: doc/BRIEF.md
# Embedded operation status word generator

This block decides what a flash device returns on its data bus while a program or erase algorithm runs inside it, while an erase is suspended, and after the algorithm finishes. It sits between the command sequencer, which reports the current operation through a small mode code and a start pulse, and the array read path, which supplies the stored word at the read address. A host that polls the device reads status words built from three bits in every byte lane. The polling bit is bit 7, the busy toggle bit is bit 6 and the suspend toggle bit is bit 2. The host infers progress from how these bits change between successive reads.

A read cycle is the time during which both active-low strobes, output enable and chip select, are low. The cycle ends when either strobe returns high. That end is the event that advances the toggle bits, so a host may pace its polling with either strobe. The word width is a parameter and holds one or more byte lanes. Each lane carries its own copy of the status pattern, and each lane has its own copy of bit 7 of the data being programmed. Sectors are defined by the address bits at and above a parameterised position.

Top module: `opstat_gen`

## Requirements
- R1: With mode code 0 (idle), `dout` equals `arr_data` at all times, including right after reset.
- R2: With mode code 1 (program busy), bit 7 of each byte lane of `dout` is the inverse of that lane's bit in `prog_d7`.
- R3: With mode code 2 (erase busy), bit 7 of every byte lane of `dout` reads 0.
- R4: While the mode is 1 or 2, bit 6 of every lane inverts once per completed read cycle. The first read after an operation start shows 0.
- R5: A read cycle is a span with both `oe_n` and `ce_n` low. It completes when either strobe goes high first, and each completed cycle counts as exactly one toggle event.
- R6: Bit 2 of every lane keeps its value through reads made in modes 1 and 2. It inverts only on a completed read whose address is in the suspended sector while the mode is 3.
- R7: With mode code 3 (erase suspended), a read outside the suspended sector returns `arr_data` and changes neither toggle bit. Two addresses share a sector when they agree in the bits from position SECT_LSB upward.
- R8: With mode code 3, a read inside the suspended sector returns bit 7 = 1, bit 6 held at its last value, and bit 2 = the suspend toggle value in each lane.
- R9: A pulse on `op_start` clears both toggle bits to 0. It takes effect whatever toggle values the earlier operation left behind.
- R10: `ready` is low exactly while the mode is 1 or 2, and high in modes 0 and 3.
- R11: In status words, every bit other than 7, 6 and 2 of each lane reads 0, and all lanes carry the same bit 6 and bit 2.
- R12: On the first read after the mode returns to 0, true array data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | Operation state: 0 idle, 1 program busy, 2 erase busy, 3 erase suspended |
| op_start | input | 1 | One-cycle pulse when a new program or erase begins |
| prog_d7 | input | DATA_W/8 | Bit 7 of the data being programmed, one per byte lane |
| susp_addr | input | ADDR_W | An address inside the erase-suspended sector |
| rd_addr | input | ADDR_W | Address of the current read |
| oe_n | input | 1 | Output enable strobe, active low |
| ce_n | input | 1 | Chip select strobe, active low |
| arr_data | input | DATA_W | Array word at `rd_addr` from the storage path |
| dout | output | DATA_W | Word presented on the read bus |
| ready | output | 1 | High when no embedded algorithm is running |

## Verification
The bench builds the block with a 32-bit word, which gives four byte lanes. Each lane gets a different programmed bit 7, so a lane-swap or a single shared polling bit becomes visible. The address is 12 bits with SECT_LSB = 10, which leaves only four sectors. Random read addresses during an erase suspend then fall inside the suspended sector about a quarter of the time, and the rules for in-sector and out-of-sector reads are both exercised often. Reads that end on `oe_n` alternate with reads that end on `ce_n`. Operation restarts are also issued while the suspend toggle is nonzero, so the clear path is exercised.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_ESUSP = 2'd3
   } op_mode_e;

   localparam int LANE_W   = 8;
   localparam int POLL_BIT = 7;
   localparam int BUSY_BIT = 6;
   localparam int SUSP_BIT = 2;

endpackage

// File: rtl/opstat_strobe.sv
module opstat_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   input  logic ce_n,
   output logic rd_act,
   output logic rd_end
);
   logic act_q;

   assign rd_act = ~oe_n & ~ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= rd_act;
   end

   // Whichever strobe rises first closes the cycle; the second one adds nothing.
   assign rd_end = act_q & ~rd_act;

   p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end |=> !rd_end);

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd_end,
   input  logic busy,
   input  logic sus_hit,
   output logic t_busy,
   output logic t_susp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_busy <= 1'b0;
         t_susp <= 1'b0;
      end else if (start) begin
         t_busy <= 1'b0;
         t_susp <= 1'b0;
      end else if (rd_end) begin
         if (busy)    t_busy <= ~t_busy;
         if (sus_hit) t_susp <= ~t_susp;
      end
   end

   p_busy_moves_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(t_busy) |-> $past(start || (rd_end && busy)));

   p_busy_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && busy && !start) |=> (t_busy != $past(t_busy)));

   p_susp_only_in_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(t_susp) |-> $past(start || (rd_end && sus_hit)));

   p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!t_busy && !t_susp));

endmodule

// File: rtl/opstat_lane_mux.sv
module opstat_lane_mux
   import opstat_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / LANE_W
) (
   input  op_mode_e             mode,
   input  logic [LANES-1:0]     pd7,
   input  logic                 hit,
   input  logic                 t_busy,
   input  logic                 t_susp,
   input  logic [DATA_W-1:0]    arr,
   output logic [DATA_W-1:0]    word
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] stat;
      logic [LANE_W-1:0] lane;

      always_comb begin
         stat           = '0;
         stat[BUSY_BIT] = t_busy;
         stat[SUSP_BIT] = t_susp;
         lane           = arr[g*LANE_W +: LANE_W];
         unique case (mode)
            OP_IDLE:  lane = arr[g*LANE_W +: LANE_W];
            OP_PROG: begin
               stat[POLL_BIT] = ~pd7[g];
               lane           = stat;
            end
            OP_ERASE: begin
               stat[POLL_BIT] = 1'b0;
               lane           = stat;
            end
            OP_ESUSP: begin
               stat[POLL_BIT] = 1'b1;
               if (hit) lane = stat;
            end
            default:  lane = arr[g*LANE_W +: LANE_W];
         endcase
      end

      assign word[g*LANE_W +: LANE_W] = lane;
   end

endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
   import opstat_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int SECT_LSB = 16,
   parameter int DATA_W   = 32,
   localparam int LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_mode,
   input  logic              op_start,
   input  logic [LANES-1:0]  prog_d7,
   input  logic [ADDR_W-1:0] susp_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              oe_n,
   input  logic              ce_n,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] dout,
   output logic              ready
);

   if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin : g_bad_width
      $error("opstat_gen: DATA_W must be a nonzero multiple of 8");
   end
   if (SECT_LSB < 0 || SECT_LSB >= ADDR_W) begin : g_bad_sector
      $error("opstat_gen: SECT_LSB must lie inside the address");
   end

   op_mode_e mode;
   logic     rd_act, rd_end, hit, busy, t_busy, t_susp;

   assign mode = op_mode_e'(op_mode);
   assign busy = (mode == OP_PROG) || (mode == OP_ERASE);
   assign hit  = (rd_addr >> SECT_LSB) == (susp_addr >> SECT_LSB);

   opstat_strobe u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_n   (oe_n),
      .ce_n   (ce_n),
      .rd_act (rd_act),
      .rd_end (rd_end)
   );

   opstat_toggle u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (op_start),
      .rd_end  (rd_end),
      .busy    (busy),
      .sus_hit ((mode == OP_ESUSP) && hit),
      .t_busy  (t_busy),
      .t_susp  (t_susp)
   );

   opstat_lane_mux #(.DATA_W(DATA_W)) u_mux (
      .mode   (mode),
      .pd7    (prog_d7),
      .hit    (hit),
      .t_busy (t_busy),
      .t_susp (t_susp),
      .arr    (arr_data),
      .word   (dout)
   );

   assign ready = ~busy;

   p_idle_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && op_mode == 2'd0) |-> (dout == arr_data));

   p_outside_sector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 2'd3 && !hit) |-> (dout == arr_data));

endmodule

// File: tb/opstat_gen_tb.sv
`timescale 1ns/1ps
module opstat_gen_tb;

   localparam int AW = 12;
   localparam int SL = 10;
   localparam int DW = 32;
   localparam int LN = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_mode = 2'd0;
   logic          op_start = 1'b0;
   logic [LN-1:0] prog_d7 = '0;
   logic [AW-1:0] susp_addr = '0;
   logic [AW-1:0] rd_addr = '0;
   logic          oe_n = 1'b1;
   logic          ce_n = 1'b1;
   logic [DW-1:0] arr_data;
   logic [DW-1:0] dout;
   logic          ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [1:0]    m_mode = 2'd0;
   logic [LN-1:0] m_pd7 = '0;
   logic          m_tb = 1'b0;
   logic          m_ts = 1'b0;
   bit            end_on_ce = 1'b0;

   always #4 clk = ~clk;

   // array stub: word derived from the address
   assign arr_data = {4'h5, rd_addr, ~rd_addr[3:0], rd_addr ^ 12'hA5C};

   opstat_gen #(.ADDR_W(AW), .SECT_LSB(SL), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_start(op_start),
      .prog_d7(prog_d7), .susp_addr(susp_addr), .rd_addr(rd_addr),
      .oe_n(oe_n), .ce_n(ce_n), .arr_data(arr_data), .dout(dout), .ready(ready)
   );

   function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
      return {4'h5, a, ~a[3:0], a ^ 12'hA5C};
   endfunction

   function automatic logic in_sector(input logic [AW-1:0] a, input logic [AW-1:0] s);
      return a[AW-1:SL] == s[AW-1:SL];
   endfunction

   function automatic logic [DW-1:0] exp_word(input logic [1:0] md, input logic [LN-1:0] pd,
         input logic [AW-1:0] a, input logic [AW-1:0] s, input logic tb, input logic ts);
      logic [DW-1:0] w;
      logic [DW-1:0] arr;
      logic [7:0]    st;
      arr = arr_of(a);
      w = arr;
      for (int l = 0; l < LN; l++) begin
         st = 8'h00;
         st[6] = tb;
         st[2] = ts;
         case (md)
            2'd1: begin st[7] = ~pd[l]; w[l*8 +: 8] = st; end
            2'd2: begin st[7] = 1'b0;   w[l*8 +: 8] = st; end
            2'd3: if (in_sector(a, s)) begin st[7] = 1'b1; w[l*8 +: 8] = st; end
            default: ;
         endcase
      end
      return w;
   endfunction

   task automatic check32(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_op(input logic [1:0] md, input logic [LN-1:0] pd, input bit st);
      @(negedge clk);
      op_mode = md;
      prog_d7 = pd;
      op_start = st;
      @(negedge clk);
      op_start = 1'b0;
      m_mode = md;
      m_pd7 = pd;
      if (st) begin
         m_tb = 1'b0;
         m_ts = 1'b0;
      end
   endtask

   // one read cycle, ending on oe_n or ce_n alternately (R5)
   task automatic do_read(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      rd_addr = a;
      oe_n = 1'b0;
      ce_n = 1'b0;
      @(negedge clk);
      check32(req, dout, exp_word(m_mode, m_pd7, a, susp_addr, m_tb, m_ts));
      check1("R10", ready, (m_mode == 2'd0) || (m_mode == 2'd3));
      if (end_on_ce) ce_n = 1'b1;
      else           oe_n = 1'b1;
      @(negedge clk);
      oe_n = 1'b1;
      ce_n = 1'b1;
      if (m_mode == 2'd1 || m_mode == 2'd2) m_tb = ~m_tb;
      if (m_mode == 2'd3 && in_sector(a, susp_addr)) m_ts = ~m_ts;
      end_on_ce = ~end_on_ce;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1, R10: reset state
      check32("R1", dout, arr_data);
      check1("R10", ready, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 3; i++) do_read(AW'($urandom), "R1");

      // program: per-lane polling bit, busy toggle, held suspend toggle
      set_op(2'd1, 4'b1010, 1'b1);
      do_read(12'h123, "R4 first read zero / R2 / R11");
      for (int i = 0; i < 5; i++) do_read(AW'($urandom), "R2 R4 R5 R6");

      // completion
      set_op(2'd0, 4'b1010, 1'b0);
      do_read(12'h3F0, "R12");

      // erase
      set_op(2'd2, 4'b0000, 1'b1);
      for (int i = 0; i < 5; i++) do_read(AW'($urandom), "R3 R4 R11");

      // erase suspend, mixed in-sector and outside reads
      susp_addr = 12'h812;
      set_op(2'd3, 4'b0000, 1'b0);
      do_read(12'h800, "R8 in sector");
      do_read(12'h004, "R7 outside sector");
      do_read(12'hBFF, "R8 in sector last word");
      do_read(12'hC00, "R7 next sector");
      for (int i = 0; i < 20; i++) do_read(AW'($urandom), "R7 R8");

      // resume: busy toggle continues, suspend toggle held
      if (!m_ts) do_read(12'h900, "R8");
      set_op(2'd2, 4'b0000, 1'b0);
      for (int i = 0; i < 3; i++) do_read(AW'($urandom), "R6 held on resume");

      // restart with nonzero suspend toggle
      set_op(2'd1, 4'b0101, 1'b1);
      do_read(12'h777, "R9 cleared");

      // random phase
      for (int i = 0; i < 150; i++) begin
         if ($urandom_range(0, 3) == 0) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            if (md == 2'd3) susp_addr = AW'($urandom);
            set_op(md, LN'($urandom), ($urandom_range(0, 1) == 1) && (md != 2'd3));
         end
         do_read(AW'($urandom), "R1 R2 R3 R4 R6 R7 R8 R9");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule